// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits between a processor's register-write port and a flash macro. It turns a short series of setup writes and a command write into a one-cycle erase request for a single page or for the whole array. It also steers processor data-pointer stores either to data RAM or to program flash, depending on a program-write-enable bit. An erase is started only by one of two unlock codes, and only when the matching setup write has happened since the last erase of that kind. Once an erase starts, the sequencer reports busy until the flash returns done. The cycle then stays open until software writes a zero terminator, which re-arms the sequencer.

The controller is a four-state machine:
- **IDLE** waits for an accepted command. It goes to ISSUE on an accepted page or mass command.
- **ISSUE** drives the request for exactly one cycle, then always moves to BUSY.
- **BUSY** waits for `fl_done`. When done arrives it moves to HOLD.
- **HOLD** waits for the terminator. A command write of 0x00 returns it to IDLE.

Two pieces of state sit beside the machine. A register bank holds the page, bank and control fields, along with the single-use arm flags. The store routing is a plain gate on the program-write-enable bit.

Top module: `flash_seq`

## Requirements
- R1: After reset, `er_req`, `er_busy`, `er_open` and `pwe` are 0. The page, bank and arm flags are also cleared.
- R2: Register select 1 writes the page field from `wr_data[5:0]`, and select 3 writes the bank field from `wr_data[2:0]`. A write of 0x55 to select 0 (the command register) while IDLE, with the page armed, raises `er_req` for exactly one cycle, starting the cycle after the write. On that cycle `er_mass`=0 and `er_page`={bank,page}.
- R3: A 0x55 command is refused, with no request, unless select 1 was written after the last accepted page erase.
- R4: Select 2 bit 1 sets the mass-erase arm. A 0xAA command while IDLE raises a one-cycle `er_req` with `er_mass`=1 and `er_page`=0, but only if the mass arm is set and `dbg_en` is 1. Otherwise no request is raised.
- R5: A command value other than 0x55, 0xAA or 0x00 has no effect. A 0x00 written while IDLE also has no effect.
- R6: `er_busy` is 1 from the request cycle until the cycle after `fl_done`. `er_open` then stays 1 until a 0x00 command is written. Command writes made while busy, and non-zero commands made while open, are ignored.
- R7: Each arm flag is consumed by the erase it enables. A second command of the same kind is refused until the setup write is repeated.
- R8: Select 2 bit 0 is `pwe`. With `pwe`=1, a store (`st_en`) raises `fl_we` and not `ram_we`. With `pwe`=0, it raises `ram_we` and not `fl_we`. The store address and data pass through to both sides.
- R9: A write to select 2 leaves `pwe` unchanged while `irq_en` is 1, although its bit 1 still updates the mass arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 page, 2 control, 3 bank |
| wr_data | input | 8 | Register write data |
| dbg_en | input | 1 | Debug port enabled |
| irq_en | input | 1 | Interrupts globally enabled |
| st_en | input | 1 | Data-pointer store strobe |
| st_addr | input | 16 | Store address |
| st_data | input | 8 | Store data |
| fl_done | input | 1 | Flash erase finished |
| er_req | output | 1 | One-cycle erase request |
| er_mass | output | 1 | Request mode: 1 mass, 0 page |
| er_page | output | 9 | Page number {bank,page} |
| er_busy | output | 1 | Erase in progress |
| er_open | output | 1 | Erase cycle not yet terminated |
| pwe | output | 1 | Program-write-enable state |
| fl_we | output | 1 | Byte program strobe to flash |
| ram_we | output | 1 | Write strobe to data RAM |
| mem_addr | output | 16 | Store address to flash or RAM |
| mem_data | output | 8 | Store data to flash or RAM |

## Verification
Two events can land on the same edge: the flash's done pulse and a software terminator write. The bench provokes this by raising `fl_done` and writing 0x00 on the same edge. It then checks that the terminator was dropped, because the machine was still BUSY: `er_open` must stay 1. A second 0x00 must then close the cycle. A similar overlap, where a control write lands while `irq_en` is 1, must update the mass arm without touching `pwe`.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_BUSY  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_PAGE = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_BANK = 2'd3;

    localparam logic [7:0] CMD_PAGE = 8'h55;
    localparam logic [7:0] CMD_MASS = 8'hAA;
    localparam logic [7:0] CMD_END  = 8'h00;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
    import flash_seq_pkg::*;
#(
    parameter int PAGE_W = 6,
    parameter int BANK_W = 3,
    localparam int PN_W  = PAGE_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_low,
    input  logic              irq_en,
    input  logic              take_page,
    input  logic              take_mass,
    output logic [PN_W-1:0]   page_num,
    output logic              pg_armed,
    output logic              me_armed,
    output logic              pwe_q
);
    logic [PAGE_W-1:0] page_q;
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            bank_q   <= '0;
            pg_armed <= 1'b0;
            me_armed <= 1'b0;
            pwe_q    <= 1'b0;
        end else begin
            if (take_page) pg_armed <= 1'b0;
            if (take_mass) me_armed <= 1'b0;
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_PAGE: begin
                        page_q   <= wr_low;
                        pg_armed <= 1'b1;
                    end
                    SEL_CTRL: begin
                        me_armed <= wr_low[1];
                        if (!irq_en) pwe_q <= wr_low[0];
                    end
                    SEL_BANK: bank_q <= wr_low[BANK_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign page_num = {bank_q, page_q};

    AST_PWE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |=> $stable(pwe_q)); // R9
    AST_PAGE_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        take_page |=> !pg_armed); // R7
    AST_MASS_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        take_mass |=> !me_armed); // R7
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int PN_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic [DW-1:0]   cmd_data,
    input  logic            pg_armed,
    input  logic            me_armed,
    input  logic            dbg_en,
    input  logic            fl_done,
    input  logic [PN_W-1:0] page_num,
    output logic            take_page,
    output logic            take_mass,
    output logic            er_req,
    output logic            er_mass,
    output logic [PN_W-1:0] er_page,
    output logic            er_busy,
    output logic            er_open
);
    seq_state_t state_q, state_d;
    logic            mode_q;
    logic [PN_W-1:0] page_q;
    logic            is_page, is_mass, is_end;

    assign is_page = cmd_wr && (cmd_data == DW'(CMD_PAGE));
    assign is_mass = cmd_wr && (cmd_data == DW'(CMD_MASS));
    assign is_end  = cmd_wr && (cmd_data == DW'(CMD_END));

    always_comb begin
        state_d   = state_q;
        take_page = 1'b0;
        take_mass = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_page && pg_armed) begin
                    take_page = 1'b1;
                    state_d   = ST_ISSUE;
                end else if (is_mass && me_armed && dbg_en) begin
                    take_mass = 1'b1;
                    state_d   = ST_ISSUE;
                end
            end
            ST_ISSUE: state_d = ST_BUSY;
            ST_BUSY:  if (fl_done) state_d = ST_HOLD;
            ST_HOLD:  if (is_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take_page) begin
                mode_q <= 1'b0;
                page_q <= page_num;
            end else if (take_mass) begin
                mode_q <= 1'b1;
                page_q <= '0;
            end
        end
    end

    always_comb begin
        er_req  = 1'b0;
        er_busy = 1'b0;
        er_open = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin er_req = 1'b1; er_busy = 1'b1; er_open = 1'b1; end
            ST_BUSY:  begin er_busy = 1'b1; er_open = 1'b1; end
            ST_HOLD:  er_open = 1'b1;
            default:  ;
        endcase
        er_mass = mode_q;
        er_page = page_q;
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        er_req |=> !er_req); // R2
    AST_BUSY_TILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !fl_done) |=> er_busy); // R6
    AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !is_end) |=> (state_q == ST_HOLD)); // R6
    AST_IDLE_ON_NOISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !is_page && !is_mass) |=> (state_q == ST_IDLE)); // R5
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 16,
    parameter int PAGE_W = 6,
    parameter int BANK_W = 3,
    localparam int PN_W  = PAGE_W + BANK_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            dbg_en,
    input  logic            irq_en,
    input  logic            st_en,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic            fl_done,
    output logic            er_req,
    output logic            er_mass,
    output logic [PN_W-1:0] er_page,
    output logic            er_busy,
    output logic            er_open,
    output logic            pwe,
    output logic            fl_we,
    output logic            ram_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_data
);
    logic [PN_W-1:0] page_num;
    logic pg_armed, me_armed, take_page, take_mass, cmd_wr;

    assign cmd_wr = wr_en && (wr_sel == SEL_CMD);

    flash_seq_regs #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_low(wr_data[PAGE_W-1:0]), .irq_en(irq_en),
        .take_page(take_page), .take_mass(take_mass),
        .page_num(page_num), .pg_armed(pg_armed), .me_armed(me_armed),
        .pwe_q(pwe)
    );

    flash_seq_fsm #(.DW(DW), .PN_W(PN_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(wr_data),
        .pg_armed(pg_armed), .me_armed(me_armed), .dbg_en(dbg_en),
        .fl_done(fl_done), .page_num(page_num),
        .take_page(take_page), .take_mass(take_mass),
        .er_req(er_req), .er_mass(er_mass), .er_page(er_page),
        .er_busy(er_busy), .er_open(er_open)
    );

    assign fl_we    = st_en && pwe;
    assign ram_we   = st_en && !pwe;
    assign mem_addr = st_addr;
    assign mem_data = st_data;

    AST_PAGE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(er_req) && !er_mass |-> $past(pg_armed)); // R3
    AST_MASS_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(er_req) && er_mass |-> ($past(dbg_en) && $past(me_armed))); // R4
    AST_OPEN_COVERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        er_busy |-> er_open); // R6
endmodule

// File: tb/flash_seq_tb_top.sv
`timescale 1ns/1ps
module flash_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic dbg_en = 1'b0, irq_en = 1'b0, st_en = 1'b0, fl_done = 1'b0;
    logic [15:0] st_addr = '0;
    logic [7:0] st_data = '0;
    logic er_req, er_mass, er_busy, er_open, pwe, fl_we, ram_we;
    logic [8:0] er_page;
    logic [15:0] mem_addr;
    logic [7:0] mem_data;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    flash_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .dbg_en(dbg_en), .irq_en(irq_en), .st_en(st_en),
        .st_addr(st_addr), .st_data(st_data), .fl_done(fl_done),
        .er_req(er_req), .er_mass(er_mass), .er_page(er_page),
        .er_busy(er_busy), .er_open(er_open), .pwe(pwe), .fl_we(fl_we),
        .ram_we(ram_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // {sel, data, dbg, irq, exp_req, exp_mass, exp_page, exp_pwe}
    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] data;
        logic       dbg;
        logic       irq;
        logic       req;
        logic       mass;
        logic [8:0] page;
        logic       pw;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R2 bank
        '{2'd0, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R3 unarmed
        '{2'd1, 8'h2A, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R2 page
        '{2'd0, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R5
        '{2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R5
        '{2'd0, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 9'd362, 1'b0}, // R2
        '{2'd0, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R7
        '{2'd0, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R4 unarmed
        '{2'd2, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R4 arm
        '{2'd0, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R4 no dbg
        '{2'd0, 8'hAA, 1'b1, 1'b0, 1'b1, 1'b1, 9'd0,   1'b0}, // R4
        '{2'd0, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R7
        '{2'd2, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b1}, // R8 set
        '{2'd2, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0,   1'b1}, // R9
        '{2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   1'b0}, // R8 clear
        '{2'd2, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0,   1'b0}  // R9
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a register write at a falling edge; it is captured at the next rising edge.
    task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_erase();
        @(negedge clk);
        check("R6 busy", 16'(er_busy), 16'd1);
        fl_done = 1'b1;
        @(negedge clk);
        fl_done = 1'b0;
        check("R6 open after done", {15'd0, er_open}, 16'd1);
        check("R6 not busy", {15'd0, er_busy}, 16'd0);
        reg_write(2'd0, 8'h00);
        check("R6 closed", {15'd0, er_open}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 req",  {15'd0, er_req},  16'd0);
        check("R1 busy", {15'd0, er_busy}, 16'd0);
        check("R1 open", {15'd0, er_open}, 16'd0);
        check("R1 pwe",  {15'd0, pwe},     16'd0);

        for (int i = 0; i < NV; i++) begin
            dbg_en = VECS[i].dbg;
            irq_en = VECS[i].irq;
            reg_write(VECS[i].sel, VECS[i].data);
            check($sformatf("R2-vec%0d req", i), {15'd0, er_req}, {15'd0, VECS[i].req});
            check($sformatf("R9-vec%0d pwe", i), {15'd0, pwe}, {15'd0, VECS[i].pw});
            if (VECS[i].req) begin
                check($sformatf("R4-vec%0d mode", i), {15'd0, er_mass}, {15'd0, VECS[i].mass});
                check($sformatf("R2-vec%0d page", i), {7'd0, er_page}, {7'd0, VECS[i].page});
                finish_erase();
            end
            irq_en = 1'b0;
        end

        // R8 store routing
        irq_en = 1'b0;
        reg_write(2'd2, 8'h01);
        @(negedge clk);
        st_en = 1'b1; st_addr = 16'h1234; st_data = 8'h5A;
        #1;
        check("R8 fl_we", {15'd0, fl_we}, 16'd1);
        check("R8 ram_we off", {15'd0, ram_we}, 16'd0);
        check("R8 addr", mem_addr, 16'h1234);
        st_en = 1'b0;
        reg_write(2'd2, 8'h00);
        st_en = 1'b1;
        #1;
        check("R8 ram_we", {15'd0, ram_we}, 16'd1);
        check("R8 fl_we off", {15'd0, fl_we}, 16'd0);
        st_en = 1'b0;

        // R6: command writes while busy are ignored; done and terminator on the same edge
        reg_write(2'd1, 8'h03);
        reg_write(2'd0, 8'h55);
        check("R2 page req", {15'd0, er_req}, 16'd1);
        check("R2 page num", {7'd0, er_page}, 16'd323);
        reg_write(2'd0, 8'h00);           // captured in BUSY: ignored
        check("R6 term while busy", {15'd0, er_busy}, 16'd1);
        reg_write(2'd1, 8'h04);           // re-arm page
        reg_write(2'd0, 8'h55);           // while busy: ignored
        check("R6 cmd while busy", {15'd0, er_req}, 16'd0);
        @(negedge clk);
        fl_done = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        fl_done = 1'b0; wr_en = 1'b0;
        check("R6 same-edge term dropped", {15'd0, er_open}, 16'd1);
        reg_write(2'd0, 8'h55);           // HOLD: non-zero ignored
        check("R6 cmd in hold", {15'd0, er_req}, 16'd0);
        check("R6 still open", {15'd0, er_open}, 16'd1);
        reg_write(2'd0, 8'h00);
        check("R6 closed", {15'd0, er_open}, 16'd0);
        reg_write(2'd0, 8'h55);           // page still armed from earlier write
        check("R3 armed kept", {15'd0, er_req}, 16'd1);
        check("R3 page num", {7'd0, er_page}, 16'd324);
        finish_erase();

        // R9: control write with interrupts on still arms mass erase
        irq_en = 1'b1;
        reg_write(2'd2, 8'h03);
        irq_en = 1'b0;
        check("R9 pwe held", {15'd0, pwe}, 16'd0);
        dbg_en = 1'b1;
        reg_write(2'd0, 8'hAA);
        check("R9 mass armed", {15'd0, er_req}, 16'd1);
        check("R4 mass mode", {15'd0, er_mass}, 16'd1);
        finish_erase();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule